// File: doc/BRIEF.md
# Multi-semantics float-to-integer converter

This block turns a double-format floating-point operand into an integer for the integer register file. A single datapath serves three conversion semantics. The first is the standard one: it saturates to the integer range, and NaN gives the minimum integer. The second is a saturating form in which NaN gives zero. The third is a JavaScript-style modular form: the rounded value wraps modulo 2^N, and NaN or either infinity gives zero. Each semantics can round with the dynamic rounding mode presented alongside the operand, or can be forced to truncate.

The result may be 32 or 64 bits wide, signed or unsigned. A single-precision source arrives already widened to double format, so it needs no separate path. A conversion is accepted on a cycle with `in_valid` high, and its result is presented one clock later on `out_valid`. Illegal mode codes raise `out_illegal` instead of producing a result.

Top module: `fp2int_cvt`

## Requirements
- R1: A conversion taken with `in_valid` high and a legal mode appears on `out_result` with `out_valid` high on the next rising clock edge. After reset, `out_valid`, `out_illegal` and `out_result` are all zero.
- R2: Mode codes 3'b110 and 3'b111 are illegal. One cycle later `out_illegal` is high, `out_valid` is low and `out_result` is zero.
- R3: Mode bit 0 set forces rounding toward zero. With bit 0 clear, `in_rmode` selects the rounding: 2'b00 nearest-even, 2'b01 toward zero, 2'b10 toward +infinity, 2'b11 toward -infinity.
- R4: In standard semantics (mode bits [2:1] = 2'b00), NaN gives the minimum integer of the selected width and signedness.
- R5: In saturating NaN-to-zero semantics (mode bits [2:1] = 2'b01), NaN gives zero.
- R6: In both saturating semantics, saturation is decided after rounding. A rounded value at or above the maximum gives the maximum, and one at or below the minimum gives the minimum. Infinities saturate by their sign.
- R7: In modular semantics (mode bits [2:1] = 2'b10), NaN, +infinity and -infinity give zero.
- R8: In modular semantics, the rounded value is reduced modulo 2^N to a non-negative remainder. That remainder is then read as an N-bit signed or unsigned integer. This holds for magnitudes far above 2^64.
- R9: With `in_wide` = 1, N is 64; with `in_wide` = 0, N is 32. `in_signed` = 1 selects the range -2^(N-1) to 2^(N-1)-1, and 0 selects 0 to 2^N-1. A 32-bit result is sign-extended to 64 bits when signed and zero-extended when unsigned.
- R10: Both zeros convert to integer zero, and so do subnormal operands under truncation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand and controls are presented this cycle |
| in_operand | input | 64 | Double-format floating-point operand |
| in_mode | input | 3 | Semantics in bits [2:1], truncation force in bit 0 |
| in_rmode | input | 2 | Dynamic rounding mode |
| in_wide | input | 1 | 1: 64-bit result, 0: 32-bit result |
| in_signed | input | 1 | 1: signed result, 0: unsigned result |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Integer result, extended to 64 bits |
| out_illegal | output | 1 | The previous request carried an illegal mode |

## Verification
Rounding interacts with range limits in two hard cases. One is an operand just below a limit that rounds onto it, such as 2^31-0.5 under nearest-even. The other is a small negative value converted to unsigned, which either rounds to zero or saturates. Uniform random doubles almost never land on ties or on these boundaries. The stimulus therefore biases exponents into the range near 2^31 and 2^63, clears low fraction bits so that half-way cases occur often, and adds directed tie and boundary vectors. Wrap-around for huge magnitudes needs exponents between 64 and 130, and the generator draws a separate band for them.

// File: rtl/fp2int_cvt.sv
module fp2int_cvt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_operand,
  input  logic [2:0]  in_mode,
  input  logic [1:0]  in_rmode,
  input  logic        in_wide,
  input  logic        in_signed,
  output logic        out_valid,
  output logic [63:0] out_result,
  output logic        out_illegal
);
  localparam int FW   = 52;
  localparam int EW   = 11;
  localparam int MW   = FW + 1;
  localparam int IW   = 64;
  localparam int XW   = IW + MW;
  localparam int BIAS = (1 << (EW - 1)) - 1;

  logic          sgn;
  logic [EW-1:0] expo;
  logic [FW-1:0] frac;
  assign {sgn, expo, frac} = in_operand;

  logic top, nan, legal;
  logic [1:0] sem;
  assign top   = &expo;
  assign nan   = top & (|frac);
  assign sem   = in_mode[2:1];
  assign legal = (sem != 2'b11);

  logic signed [EW+1:0] ue;
  logic [MW-1:0]        man;
  assign ue  = $signed({2'b00, expo}) - (EW+2)'(BIAS);
  assign man = {|expo, frac};

  // value = man * 2^(ue-52); place it on a grid with MW fraction bits
  logic          in_fx, huge;
  logic [6:0]    fx_sh;
  logic [XW-1:0] fx;
  assign in_fx = (ue >= -1) && (ue <= 63);
  assign huge  = (ue >= 64) && !top;
  assign fx_sh = 7'(ue + 13'sd1);
  assign fx    = {{IW{1'b0}}, man} << fx_sh;

  logic [IW-1:0] int_part, big_low;
  logic          rbit, sbit;
  logic [5:0]    big_sh;
  assign int_part = in_fx ? fx[XW-1:MW] : '0;
  assign rbit     = in_fx & fx[MW-1];
  assign sbit     = in_fx ? (|fx[MW-2:0]) : ((|expo) | (|frac));
  assign big_sh   = 6'(ue - 13'sd52);
  assign big_low  = (ue <= 115) ? ({{(IW-MW){1'b0}}, man} << big_sh) : '0;

  logic [1:0] rm;
  logic       inc;
  assign rm = in_mode[0] ? 2'b01 : in_rmode;
  always_comb begin
    case (rm)
      2'b00:   inc = rbit & (sbit | int_part[0]);
      2'b01:   inc = 1'b0;
      2'b10:   inc = ~sgn & (rbit | sbit);
      default: inc = sgn & (rbit | sbit);
    endcase
  end

  logic [IW:0]   mag65;
  logic [IW-1:0] mag, neg_mag, wrap, lim, smax, smin, umax;
  logic          ovf;
  assign mag65   = {1'b0, int_part} + {{IW{1'b0}}, inc};
  assign mag     = huge ? big_low : mag65[IW-1:0];
  assign ovf     = huge | top | mag65[IW];
  assign neg_mag = -mag;
  assign wrap    = sgn ? neg_mag : mag;
  assign lim     = in_wide ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
  assign smax    = lim - 64'd1;
  assign smin    = in_wide ? lim : 64'hFFFF_FFFF_8000_0000;
  assign umax    = in_wide ? '1 : 64'h0000_0000_FFFF_FFFF;

  logic [IW-1:0] res;
  always_comb begin
    if (sem == 2'b10) begin
      if (top)          res = '0;
      else if (in_wide) res = wrap;
      else if (in_signed) res = {{32{wrap[31]}}, wrap[31:0]};
      else              res = {32'h0, wrap[31:0]};
    end else if (nan) begin
      res = (sem == 2'b00 && in_signed) ? smin : '0;
    end else if (in_signed) begin
      if (!sgn) res = (ovf || mag >= lim) ? smax : mag;
      else      res = (ovf || mag > lim)  ? smin : neg_mag;
    end else begin
      if (sgn)  res = '0;
      else      res = (ovf || (!in_wide && |mag[63:32])) ? umax : mag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
    end else begin
      out_valid   <= in_valid & legal;
      out_illegal <= in_valid & ~legal;
      out_result  <= (in_valid & legal) ? res : '0;
    end
  end

  p_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid) && ($past(in_mode[2:1]) != 2'b11));

  p_illegal_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mode[2:1] == 2'b11 |=> out_illegal && !out_valid && out_result == '0);

  p_std_nan_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mode[2:1] == 2'b00 && nan && in_signed |=>
      out_result == ($past(in_wide) ? 64'h8000_0000_0000_0000 : 64'hFFFF_FFFF_8000_0000));

  p_rust_nan_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mode[2:1] == 2'b01 && nan |=> out_result == '0);

  p_unsigned_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_mode[2] && !in_signed && sgn && !nan |=> out_result == '0);

  p_js_special_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mode[2:1] == 2'b10 && top |=> out_result == '0);

  p_narrow_ext_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !$past(in_wide) |->
      out_result[63:32] == ($past(in_signed) ? {32{out_result[31]}} : 32'h0));
endmodule

// File: tb/tb_fp2int_cvt.sv
`timescale 1ns/1ps
module tb_fp2int_cvt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_operand = '0;
  logic [2:0]  in_mode = '0;
  logic [1:0]  in_rmode = '0;
  logic        in_wide = 1'b0;
  logic        in_signed = 1'b0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_illegal;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fp2int_cvt dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
    .in_mode(in_mode), .in_rmode(in_rmode), .in_wide(in_wide), .in_signed(in_signed),
    .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
  );

  localparam real P31 = 2147483648.0;
  localparam real P32 = 4294967296.0;
  localparam real P63 = 9223372036854775808.0;
  localparam real P64 = 18446744073709551616.0;

  function automatic logic [63:0] u64_of(input real r);
    if (r >= P63) return 64'h8000_0000_0000_0000 + 64'(longint'(r - P63));
    return 64'(longint'(r));
  endfunction

  function automatic logic [63:0] model(input logic [63:0] op, input logic [2:0] md,
                                        input logic [1:0] rmi, input logic wd, input logic sg);
    logic is_nan, is_inf, ng;
    logic [1:0] rmode;
    logic [63:0] bits, tmp;
    real r, a, fl, fr, sv, hi, m;
    is_nan = (op[62:52] == 11'h7FF) && (op[51:0] != 0);
    is_inf = (op[62:52] == 11'h7FF) && (op[51:0] == 0);
    ng = op[63];
    rmode = md[0] ? 2'b01 : rmi;
    if (md[2:1] == 2'b10 && (is_nan || is_inf)) return 64'h0;
    if (is_nan) begin
      if (md[2:1] == 2'b00 && sg) return wd ? 64'h8000_0000_0000_0000 : 64'hFFFF_FFFF_8000_0000;
      return 64'h0;
    end
    r = $bitstoreal(op);
    a = (r < 0.0) ? -r : r;
    fl = $floor(a);
    fr = a - fl;
    case (rmode)
      2'b00: begin
        if (fr > 0.5) fl = fl + 1.0;
        else if (fr == 0.5) begin
          tmp = u64_of(fl);
          if (tmp[0]) fl = fl + 1.0;
        end
      end
      2'b10: if (!ng && fr > 0.0) fl = fl + 1.0;
      2'b11: if (ng && fr > 0.0) fl = fl + 1.0;
      default: ;
    endcase
    if (md[2:1] == 2'b10) begin
      m = fl - $floor(fl / P64) * P64;
      bits = u64_of(m);
      if (ng) bits = -bits;
      if (!wd) bits = sg ? {{32{bits[31]}}, bits[31:0]} : {32'h0, bits[31:0]};
      return bits;
    end
    sv = ng ? -fl : fl;
    if (sg) begin
      hi = wd ? P63 : P31;
      if (sv >= hi) return wd ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
      if (sv < -hi) return wd ? 64'h8000_0000_0000_0000 : 64'hFFFF_FFFF_8000_0000;
      if (sv < 0.0) return -u64_of(-sv);
      return u64_of(sv);
    end
    hi = wd ? P64 : P32;
    if (sv >= hi) return wd ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    if (sv < 0.0) return 64'h0;
    return u64_of(sv);
  endfunction

  task automatic apply(input logic [63:0] op, input logic [2:0] md, input logic [1:0] rmi,
                       input logic wd, input logic sg, input string tag);
    logic [63:0] exp_res;
    logic exp_ill;
    exp_ill = (md[2:1] == 2'b11);
    exp_res = exp_ill ? 64'h0 : model(op, md, rmi, wd, sg);
    @(negedge clk);
    in_valid = 1'b1; in_operand = op; in_mode = md; in_rmode = rmi; in_wide = wd; in_signed = sg;
    @(posedge clk);
    #1;
    n_checks++;
    if (out_result !== exp_res || out_valid !== !exp_ill || out_illegal !== exp_ill) begin
      n_fail++;
      $display("FAIL %s op=%h mode=%b rm=%b wide=%b signed=%b: got res=%h v=%b ill=%b, expected res=%h v=%b ill=%b",
               tag, op, md, rmi, wd, sg, out_result, out_valid, out_illegal, exp_res, !exp_ill, exp_ill);
    end
  endtask

  function automatic logic [63:0] rand_op();
    logic [63:0] op;
    logic [51:0] fr;
    logic [10:0] e;
    int k;
    k = int'($urandom % 16);
    fr = {$urandom, $urandom};
    if ($urandom % 2 == 0) fr[39:0] = '0;
    case (k)
      0: begin e = 11'd0; fr = '0; end
      1: begin e = 11'h7FF; fr[0] = 1'b1; end
      2: begin e = 11'h7FF; fr = '0; end
      3: e = 11'd0;
      4, 5: e = 11'(1023 + 60 + $urandom % 71);
      default: e = 11'(1020 + $urandom % 70);
    endcase
    op = {1'($urandom), e, fr};
    return op;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7391));
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if (out_valid !== 1'b0 || out_illegal !== 1'b0 || out_result !== 64'h0) begin
      n_fail++;
      $display("FAIL R1 reset: got v=%b ill=%b res=%h, expected 0 0 0", out_valid, out_illegal, out_result);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R3 rounding directions
    apply($realtobits(2.5), 3'b000, 2'b00, 1'b1, 1'b1, "R3 tie even down");
    apply($realtobits(1.5), 3'b000, 2'b00, 1'b1, 1'b1, "R3 tie even up");
    apply($realtobits(-2.5), 3'b010, 2'b10, 1'b1, 1'b1, "R3 toward +inf negative");
    apply($realtobits(-2.25), 3'b000, 2'b11, 1'b0, 1'b1, "R3 toward -inf");
    apply($realtobits(2.75), 3'b001, 2'b10, 1'b1, 1'b1, "R3 forced truncate");
    apply($realtobits(2.75), 3'b100, 2'b01, 1'b0, 1'b0, "R3 dynamic toward zero");
    // R4 / R5
    apply(64'h7FF8_0000_0000_0000, 3'b000, 2'b00, 1'b0, 1'b1, "R4 nan std signed32");
    apply(64'hFFF8_0000_0000_0001, 3'b001, 2'b00, 1'b1, 1'b1, "R4 nan std signed64");
    apply(64'h7FF8_0000_0000_0000, 3'b000, 2'b00, 1'b1, 1'b0, "R4 nan std unsigned");
    apply(64'h7FF0_0000_0000_0001, 3'b010, 2'b00, 1'b1, 1'b1, "R5 nan rust");
    // R6 saturation after rounding
    apply($realtobits(2147483647.5), 3'b000, 2'b00, 1'b0, 1'b1, "R6 rounds onto max");
    apply($realtobits(2147483647.5), 3'b001, 2'b00, 1'b0, 1'b1, "R6 truncate stays below max");
    apply($realtobits(-0.4), 3'b001, 2'b00, 1'b1, 1'b0, "R6 -0.4 unsigned");
    apply($realtobits(-0.6), 3'b000, 2'b00, 1'b1, 1'b0, "R6 -0.6 unsigned");
    apply($realtobits(-2147483648.0), 3'b010, 2'b00, 1'b0, 1'b1, "R6 exact min");
    apply($realtobits(-2147483648.5), 3'b000, 2'b11, 1'b0, 1'b1, "R6 below min");
    apply($realtobits(P63), 3'b000, 2'b00, 1'b1, 1'b1, "R6 2^63 signed64");
    apply($realtobits(P64), 3'b011, 2'b00, 1'b1, 1'b0, "R6 2^64 unsigned64");
    apply(64'hFFF0_0000_0000_0000, 3'b010, 2'b00, 1'b1, 1'b1, "R6 -inf");
    apply(64'h7FF0_0000_0000_0000, 3'b000, 2'b00, 1'b0, 1'b0, "R6 +inf unsigned32");
    // R7 / R8
    apply(64'h7FF0_0000_0000_0000, 3'b100, 2'b00, 1'b1, 1'b1, "R7 js +inf");
    apply(64'hFFF0_0000_0000_0000, 3'b101, 2'b00, 1'b0, 1'b0, "R7 js -inf");
    apply(64'h7FF8_0000_0000_0000, 3'b100, 2'b00, 1'b1, 1'b0, "R7 js nan");
    apply($realtobits(P32 + 5.0), 3'b101, 2'b00, 1'b0, 1'b1, "R8 wrap 2^32+5");
    apply($realtobits(-1.0), 3'b100, 2'b00, 1'b0, 1'b0, "R8 -1 unsigned32");
    apply($realtobits(P31), 3'b100, 2'b00, 1'b0, 1'b1, "R8 2^31 signed32");
    apply($realtobits(P64 * 3.0 + 4096.0 * 4096.0), 3'b100, 2'b00, 1'b1, 1'b1, "R8 huge wrap");
    apply($realtobits(-2.5), 3'b100, 2'b00, 1'b1, 1'b1, "R8 rounds before wrap");
    // R9 / R10
    apply($realtobits(-7.0), 3'b000, 2'b00, 1'b0, 1'b1, "R9 sign extend 32");
    apply($realtobits(P32 - 1.0), 3'b010, 2'b00, 1'b0, 1'b0, "R9 unsigned32 max exact");
    apply(64'h8000_0000_0000_0000, 3'b000, 2'b10, 1'b1, 1'b1, "R10 negative zero");
    apply(64'h8000_0000_0000_0001, 3'b011, 2'b00, 1'b1, 1'b1, "R10 subnormal");
    // R2
    apply($realtobits(3.0), 3'b110, 2'b00, 1'b1, 1'b1, "R2 mode 110");
    apply($realtobits(3.0), 3'b111, 2'b00, 1'b1, 1'b1, "R2 mode 111");

    for (int i = 0; i < 4000; i++) begin
      logic [2:0] md;
      md = 3'($urandom % 8);
      apply(rand_op(), md, 2'($urandom), 1'($urandom), 1'($urandom),
            md[2:1] == 2'b11 ? "R2 random" : (md[2] ? "R8 random" : "R6 random"));
    end

    @(negedge clk);
    in_valid = 1'b0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule